// File: doc/BRIEF.md
# Register-Mapped SPI Master Core

A CPU drives this SPI master through a small register port of 32-bit words. The CPU picks a chip select and asserts it with one control write. It sets the clock mode, word size and bit order in the configuration register. A write to the transmit register sends one 8-bit or 16-bit word. While that word goes out on MOSI, the block collects the word that arrives on MISO. When the word completes, the block raises a done flag in the cause register. The CPU reads the received word and clears the flag before it sends the next word.

The block makes no serial clock of its own. A separate prescaler supplies a one-cycle clock-enable, and each enable pulse produces exactly one SCK edge. A timing register moves the MISO capture point from the SCK edge to one system clock after it. This gives margin for slow return paths at high serial rates.

Top module: `spim_core`

## Requirements
- R1: After reset all chip-select lines are high, SCK is low, and the cause register reads 0. The control and configuration registers read 0, and the timing register reads 0x40.
- R2: Control register (offset 0x00): bit 0 is the assert bit and bits 4:2 are the chip-select index. Line `cs_n[i]` is low only when the assert bit is set and the index equals i, so at most one line is low at a time. One write changes the index and the assert bit together, and `cs_n` changes only after a bus write.
- R3: Configuration register (offset 0x04): bit 5 selects 16-bit words, bit 11 is clock polarity, bit 12 is clock phase, bit 13 sends LSB first and bit 14 receives LSB first. These five bits read back as written, and all other bits read 0.
- R4: A write to the data-out register (offset 0x08) while idle starts one word. With bit 13 clear, the word goes out MSB first from bit 7 (8-bit mode) or bit 15 (16-bit mode).
- R5: In 16-bit mode a transfer has 16 bits and 32 SCK edges, using the low 16 bits of the data registers. In 8-bit mode it has 8 bits and 16 edges, using the low 8 bits.
- R6: The transmit and receive bit orders are set independently by configuration bits 13 and 14.
- R7: SCK rests at the polarity bit. With phase 0, MISO is captured on the leading edges and MOSI changes on the trailing edges. The first MOSI bit is driven when the transfer starts. With phase 1, MOSI changes on the leading edges and MISO is captured on the trailing edges.
- R8: The cause register (offset 0x10) reads 1 from the cycle after the last SCK edge has been processed. It reads 0 after any write to it and after a new transfer starts.
- R9: The data-in register (offset 0x0C) returns the received word, zero-extended. It is valid from the first cycle in which the cause register reads 1.
- R10: A write to data-out while a transfer is in progress is ignored. The current word, its MOSI bits and the data-out readback are not affected.
- R11: Timing register (offset 0x18) bits 7:6 set when MISO is captured. Values 0 and 1 capture on the clock edge that carries the SCK edge. Values 2 and 3 capture one system clock later.
- R12: While a transfer runs, SCK toggles exactly once for each `sck_en` pulse and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sck_en | input | 1 | One-cycle pulse from the prescaler; one SCK edge per pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2**CS_IDX_W | Active-low chip selects |

## Verification
The bench builds the block with its default parameters: a 5-bit offset bus and a 3-bit chip-select index, so all eight select lines are reachable. Those eight lines are covered one by one. The bench also covers both word sizes, all four clock modes, both bit orders in each direction and all four timing field values. It holds MISO at one word until each capture edge and then switches it to a second word. The word read back therefore shows whether MISO was captured on the edge or one clock after it.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BUS_W       = 32;
    localparam int MAX_BITS    = 16;
    localparam int NARROW_BITS = 8;
    localparam int IDX_W       = $clog2(MAX_BITS);
    localparam int CNT_W       = $clog2(2 * MAX_BITS);

    // register offsets
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_CFG    = 'h04;
    localparam int OFS_TXD    = 'h08;
    localparam int OFS_RXD    = 'h0C;
    localparam int OFS_CAUSE  = 'h10;
    localparam int OFS_TIMING = 'h18;

    // field positions
    localparam int CTL_ASSERT = 0;
    localparam int CTL_IDX_LO = 2;
    localparam int CFG_WIDE   = 5;
    localparam int CFG_CPOL   = 11;
    localparam int CFG_CPHA   = 12;
    localparam int CFG_TXLSB  = 13;
    localparam int CFG_RXLSB  = 14;
    localparam int TIM_LO     = 6;
    localparam logic [1:0] TIM_RESET = 2'b01;

    typedef struct packed {
        logic rx_lsb;
        logic tx_lsb;
        logic cpha;
        logic cpol;
        logic wide;
    } spim_cfg_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_RUN,
        SH_FLUSH
    } spim_state_t;

    // Maps a word to wire order (bit i = i-th bit on the wire) or back; the
    // mapping is its own inverse. Bits beyond the word size come out zero.
    function automatic logic [MAX_BITS-1:0] wire_order(
        input logic [MAX_BITS-1:0] w,
        input logic                wide,
        input logic                lsb_first
    );
        logic [MAX_BITS-1:0] o;
        int nb;
        nb = wide ? MAX_BITS : NARROW_BITS;
        o  = '0;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (i < nb) begin
                o[i] = lsb_first ? w[i] : w[nb-1-i];
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CS_IDX_W = 3,
    localparam int NUM_CS  = 1 << CS_IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                busy,
    input  logic                word_done,
    input  logic [MAX_BITS-1:0] rx_word,
    output spim_cfg_t           cfg,
    output logic                late_sample,
    output logic                start,
    output logic [MAX_BITS-1:0] tx_word,
    output logic                cause,
    output logic [NUM_CS-1:0]   cs_n
);

    logic                cs_on;
    logic [CS_IDX_W-1:0] cs_idx;
    logic [1:0]          timing_q;

    logic wr_ctrl, wr_cfg, wr_txd, wr_cause, wr_timing;

    assign wr_ctrl   = bus_wr_en && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_cfg    = bus_wr_en && (bus_addr == ADDR_W'(OFS_CFG));
    assign wr_txd    = bus_wr_en && (bus_addr == ADDR_W'(OFS_TXD));
    assign wr_cause  = bus_wr_en && (bus_addr == ADDR_W'(OFS_CAUSE));
    assign wr_timing = bus_wr_en && (bus_addr == ADDR_W'(OFS_TIMING));

    assign start       = wr_txd && !busy;
    assign late_sample = timing_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_on    <= 1'b0;
            cs_idx   <= '0;
            cfg      <= '0;
            timing_q <= TIM_RESET;
            tx_word  <= '0;
            cause    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cs_on  <= bus_wdata[CTL_ASSERT];
                cs_idx <= bus_wdata[CTL_IDX_LO +: CS_IDX_W];
            end
            if (wr_cfg) begin
                cfg.wide   <= bus_wdata[CFG_WIDE];
                cfg.cpol   <= bus_wdata[CFG_CPOL];
                cfg.cpha   <= bus_wdata[CFG_CPHA];
                cfg.tx_lsb <= bus_wdata[CFG_TXLSB];
                cfg.rx_lsb <= bus_wdata[CFG_RXLSB];
            end
            if (wr_timing) begin
                timing_q <= bus_wdata[TIM_LO +: 2];
            end
            if (start) begin
                tx_word <= bus_wdata[MAX_BITS-1:0];
            end
            if (word_done) begin
                cause <= 1'b1;
            end else if (start || wr_cause) begin
                cause <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(cs_on && (cs_idx == CS_IDX_W'(g)));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[CTL_ASSERT]               = cs_on;
            bus_rdata[CTL_IDX_LO +: CS_IDX_W]   = cs_idx;
        end else if (bus_addr == ADDR_W'(OFS_CFG)) begin
            bus_rdata[CFG_WIDE]  = cfg.wide;
            bus_rdata[CFG_CPOL]  = cfg.cpol;
            bus_rdata[CFG_CPHA]  = cfg.cpha;
            bus_rdata[CFG_TXLSB] = cfg.tx_lsb;
            bus_rdata[CFG_RXLSB] = cfg.rx_lsb;
        end else if (bus_addr == ADDR_W'(OFS_TXD)) begin
            bus_rdata[MAX_BITS-1:0] = tx_word;
        end else if (bus_addr == ADDR_W'(OFS_RXD)) begin
            bus_rdata[MAX_BITS-1:0] = rx_word;
        end else if (bus_addr == ADDR_W'(OFS_CAUSE)) begin
            bus_rdata[0] = cause;
        end else if (bus_addr == ADDR_W'(OFS_TIMING)) begin
            bus_rdata[TIM_LO +: 2] = timing_q;
        end
    end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sck_en,
    input  logic                start,
    input  spim_cfg_t           cfg_live,
    input  logic                late_live,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic                miso,
    output logic                sck,
    output logic                mosi,
    output logic                busy,
    output logic                word_done,
    output logic [MAX_BITS-1:0] rx_word
);

    spim_state_t         state;
    spim_cfg_t           cfg_s;
    logic                late_s;
    logic [CNT_W-1:0]    edge_cnt;
    logic                sck_ph;
    logic [MAX_BITS-1:0] tx_sr;
    logic [MAX_BITS-1:0] rx_bits, rx_bits_d;
    logic                pend;
    logic [IDX_W-1:0]    pend_idx;

    logic             run_edge, leading, samp_edge, launch_edge, last_edge;
    logic             cap_now;
    logic [IDX_W-1:0] cap_idx;
    logic [CNT_W-1:0] last_cnt;
    logic [MAX_BITS-1:0] start_ord;

    assign busy      = (state != SH_IDLE);
    assign word_done = (state == SH_FLUSH);
    assign sck       = busy ? (cfg_s.cpol ^ sck_ph) : cfg_live.cpol;

    assign last_cnt    = cfg_s.wide ? CNT_W'(2 * MAX_BITS - 1) : CNT_W'(2 * NARROW_BITS - 1);
    assign run_edge    = (state == SH_RUN) && sck_en;
    assign leading     = !edge_cnt[0];
    assign last_edge   = (edge_cnt == last_cnt);
    assign samp_edge   = cfg_s.cpha ? !leading : leading;
    assign launch_edge = cfg_s.cpha ? leading : (!leading && !last_edge);

    assign start_ord = wire_order(tx_word, cfg_live.wide, cfg_live.tx_lsb);

    assign cap_now = pend || (run_edge && samp_edge && !late_s);
    assign cap_idx = pend ? pend_idx : edge_cnt[CNT_W-1:1];

    always_comb begin
        rx_bits_d = rx_bits;
        if (cap_now) begin
            rx_bits_d[cap_idx] = miso;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            cfg_s    <= '0;
            late_s   <= 1'b0;
            edge_cnt <= '0;
            sck_ph   <= 1'b0;
            tx_sr    <= '0;
            mosi     <= 1'b0;
            rx_bits  <= '0;
            pend     <= 1'b0;
            pend_idx <= '0;
            rx_word  <= '0;
        end else begin
            rx_bits <= rx_bits_d;
            pend    <= 1'b0;
            unique case (state)
                SH_IDLE: begin
                    if (start) begin
                        state    <= SH_RUN;
                        cfg_s    <= cfg_live;
                        late_s   <= late_live;
                        edge_cnt <= '0;
                        sck_ph   <= 1'b0;
                        mosi     <= start_ord[0];
                        tx_sr    <= cfg_live.cpha ? start_ord : (start_ord >> 1);
                    end
                end
                SH_RUN: begin
                    if (sck_en) begin
                        sck_ph   <= !sck_ph;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (launch_edge) begin
                            mosi  <= tx_sr[0];
                            tx_sr <= tx_sr >> 1;
                        end
                        if (samp_edge && late_s) begin
                            pend     <= 1'b1;
                            pend_idx <= edge_cnt[CNT_W-1:1];
                        end
                        if (last_edge) begin
                            state <= SH_FLUSH;
                        end
                    end
                end
                SH_FLUSH: begin
                    state   <= SH_IDLE;
                    rx_word <= wire_order(rx_bits_d, cfg_s.wide, cfg_s.rx_lsb);
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spim_core.sv
module spim_core
    import spim_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CS_IDX_W = 3,
    localparam int NUM_CS  = 1 << CS_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              sck_en,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    spim_cfg_t           cfg;
    logic                late_sample;
    logic                start;
    logic [MAX_BITS-1:0] tx_word;
    logic [MAX_BITS-1:0] rx_word;
    logic                shf_busy;
    logic                shf_done;
    logic                irq_cause;

    spim_regs #(
        .ADDR_W   (ADDR_W),
        .CS_IDX_W (CS_IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .busy        (shf_busy),
        .word_done   (shf_done),
        .rx_word     (rx_word),
        .cfg         (cfg),
        .late_sample (late_sample),
        .start       (start),
        .tx_word     (tx_word),
        .cause       (irq_cause),
        .cs_n        (cs_n)
    );

    spim_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .sck_en    (sck_en),
        .start     (start),
        .cfg_live  (cfg),
        .late_live (late_sample),
        .tx_word   (bus_wdata[MAX_BITS-1:0]),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .busy      (shf_busy),
        .word_done (shf_done),
        .rx_word   (rx_word)
    );

endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sck_en,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              bus_wr_en,
    input logic              busy,
    input logic              word_done,
    input logic              cause
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> ((&cs_n) && !cause && !busy));

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_cs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_en |=> $stable(cs_n));

    assert_done_sets_cause_R8: assert property (@(posedge clk) disable iff (rst)
        word_done |=> cause);

    assert_cause_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cause) |-> $past(word_done));

    assert_mosi_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !sck_en) |=> (!busy || $stable(mosi)));

    assert_sck_by_enable_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && !sck_en) |=> (!busy || $stable(sck)));

endmodule

bind spim_core spim_checker #(.NUM_CS(NUM_CS)) u_spim_checker (
    .clk       (clk),
    .rst       (rst),
    .sck_en    (sck_en),
    .sck       (sck),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .bus_wr_en (bus_wr_en),
    .busy      (shf_busy),
    .word_done (shf_done),
    .cause     (irq_cause)
);

// File: tb/test_spim_core.sv
module test_spim_core;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int CS_IDX_W   = 3;
    localparam int NUM_CS     = 1 << CS_IDX_W;

    localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TXD = 5'h08,
                           A_RXD = 5'h0C, A_CAUSE = 5'h10, A_TIM = 5'h18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr_en = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              sck_en = 1'b0;
    logic              sck;
    logic              mosi;
    logic              miso = 1'b0;
    logic [NUM_CS-1:0] cs_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    spim_core #(.ADDR_W(ADDR_W), .CS_IDX_W(CS_IDX_W)) i_spim_core (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_en(sck_en),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_en();
        sck_en = 1'b1;
        @(negedge clk);
        sck_en = 1'b0;
    endtask

    function automatic logic wire_bit(input logic [15:0] w, input int j, input int nb, input logic lsb);
        return lsb ? w[j] : w[nb-1-j];
    endfunction

    function automatic logic [31:0] cfg_word(input logic wide, input logic cpol, input logic cpha,
                                             input logic txl, input logic rxl);
        return (32'(wide) << 5) | (32'(cpol) << 11) | (32'(cpha) << 12) |
               (32'(txl) << 13) | (32'(rxl) << 14);
    endfunction

    // One word: A is what MISO shows up to each capture edge, B what it shows after.
    task automatic run_word(input logic cpol, input logic cpha, input logic wide,
                            input logic txl, input logic rxl, input logic [1:0] tim,
                            input logic [15:0] tx, input logic [15:0] wa, input logic [15:0] wb,
                            input bit inject);
        int nb;
        int mosi_bad;
        int sck_bad;
        logic [31:0] rd;
        logic [15:0] mask;
        logic [15:0] expd;
        nb = wide ? 16 : 8;
        mask = wide ? 16'hFFFF : 16'h00FF;
        mosi_bad = 0;
        sck_bad = 0;
        bus_write(A_CFG, cfg_word(wide, cpol, cpha, txl, rxl));
        bus_write(A_TIM, 32'(tim) << 6);
        chk(sck == cpol, "R7 idle level", 32'(sck), 32'(cpol));
        bus_write(A_TXD, 32'(tx));
        bus_read(A_CAUSE, rd);
        chk(rd == 0, "R8 cleared by start", rd, 0);
        for (int k = 0; k < 2*nb; k++) begin
            bit lead;
            bit samp;
            int j;
            lead = (k % 2) == 0;
            samp = cpha ? !lead : lead;
            j = k / 2;
            if (samp) begin
                miso = wire_bit(wa, j, nb, rxl);
                if (mosi !== wire_bit(tx, j, nb, txl)) mosi_bad++;
            end
            if (inject && k == 5) begin
                bus_write(A_TXD, 32'(~tx));
            end else begin
                @(negedge clk);
            end
            pulse_en();
            if (sck !== (cpol ^ lead)) sck_bad++;
            if (samp) miso = wire_bit(wb, j, nb, rxl);
        end
        bus_read(A_CAUSE, rd);
        chk(rd == 0, "R8 not before flush", rd, 0);
        @(negedge clk);
        bus_read(A_CAUSE, rd);
        chk(rd == 1, "R8 done flag", rd, 1);
        expd = (tim[1] ? wb : wa) & mask;
        bus_read(A_RXD, rd);
        chk(rd == 32'(expd), "R9/R5/R6/R11 received word", rd, 32'(expd));
        chk(mosi_bad == 0, "R4/R5/R6/R7 mosi bits", 32'(mosi_bad), 0);
        chk(sck_bad == 0, "R12/R7 sck edges", 32'(sck_bad), 0);
        chk(sck == cpol, "R7 idle after word", 32'(sck), 32'(cpol));
        if (inject) begin
            bus_read(A_TXD, rd);
            chk(rd == 32'(tx), "R10 busy write ignored", rd, 32'(tx));
        end
        bus_write(A_CAUSE, 0);
        bus_read(A_CAUSE, rd);
        chk(rd == 0, "R8 cleared by write", rd, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: all requirements, actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(cs_n == '1, "R1 cs_n", 32'(cs_n), 32'hFF);
        chk(sck == 1'b0, "R1 sck", 32'(sck), 0);
        bus_read(A_CAUSE, rd); chk(rd == 0, "R1 cause", rd, 0);
        bus_read(A_CTRL, rd);  chk(rd == 0, "R1 ctrl", rd, 0);
        bus_read(A_CFG, rd);   chk(rd == 0, "R1 cfg", rd, 0);
        bus_read(A_TIM, rd);   chk(rd == 32'h40, "R1/R11 timing", rd, 32'h40);

        // R3 configuration readback
        bus_write(A_CFG, 32'hFFFF_FFFF);
        bus_read(A_CFG, rd);
        chk(rd == 32'h7820, "R3 cfg readback", rd, 32'h7820);
        bus_write(A_CFG, 0);

        // R2 chip selects
        for (int i = 0; i < NUM_CS; i++) begin
            bus_write(A_CTRL, (32'(i) << 2) | 1);
            chk(cs_n == ~(NUM_CS'(1) << i), "R2 cs asserted", 32'(cs_n), 32'(~(NUM_CS'(1) << i)));
            bus_read(A_CTRL, rd);
            chk(rd == ((32'(i) << 2) | 1), "R2 ctrl readback", rd, (32'(i) << 2) | 1);
        end
        bus_write(A_CTRL, (32'd3 << 2) | 1);
        bus_write(A_CTRL, (32'd6 << 2) | 1);
        chk(cs_n == 8'hBF, "R2 single-write switch", 32'(cs_n), 32'hBF);
        bus_write(A_CTRL, 32'd6 << 2);
        chk(cs_n == 8'hFF, "R2 deasserted", 32'(cs_n), 32'hFF);
        bus_write(A_CTRL, (32'd2 << 2) | 1);

        // directed words
        run_word(0, 0, 0, 0, 0, 2'd1, 16'h00A5, 16'h003C, 16'h00C3, 0); // R4 basic
        run_word(1, 1, 1, 0, 0, 2'd2, 16'hBEEF, 16'h1234, 16'hEDCB, 0); // R11 late
        run_word(1, 1, 1, 0, 0, 2'd1, 16'hBEEF, 16'h1234, 16'hEDCB, 0); // R11 edge
        run_word(0, 1, 0, 1, 0, 2'd0, 16'h0081, 16'h0001, 16'h00FE, 0); // R6 tx lsb only
        run_word(1, 0, 1, 0, 1, 2'd3, 16'h8001, 16'h8000, 16'h7FFF, 0); // R6 rx lsb only
        run_word(0, 0, 1, 0, 0, 2'd1, 16'hC35A, 16'hA55A, 16'h5AA5, 1); // R10 busy write

        // random words
        for (int n = 0; n < 24; n++) begin
            logic [31:0] r;
            r = $urandom;
            run_word(r[0], r[1], r[2], r[3], r[4], r[6:5],
                     16'($urandom), 16'($urandom), 16'($urandom), r[7]);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule